// File: doc/BRIEF.md
# Power-Management Interrupt Aggregator

This block collects seven event lines from a power-management unit and presents them to a parent interrupt controller as a single level-sensitive request. Each event line is edge-detected. A rising edge latches a bit in a pending register. A second register enables or disables each line. The summary request is high while any bit is both pending and enabled.

Software reaches both registers through a simple single-cycle port with an address, a write strobe, write data and combinational read data. The pending register is plain storage, not write-one-to-clear. Each write replaces every pending bit with the written value. To acknowledge a line, software reads the register, clears the bit it has handled, and writes the value back. Bit positions map directly to line numbers, and software services lines from the lowest set bit upward.

Top module: `pmu_irq_ctrl`

## Requirements
- R1: After reset the pending register (byte offset 0x00) and the enable register (byte offset 0x04) both read 0, and `irq_o` is low.
- R2: A write to offset 0x00 replaces pending bits 6:0 with write data bits 6:0. A written 1 raises that line and a written 0 clears it.
- R3: The enable register at offset 0x04 is read/write. Bit n set to 1 enables line n (0 to 6), and bit n set to 0 disables it.
- R4: `irq_o` is high exactly when the bitwise AND of the pending and enable registers is non-zero.
- R5: `irq_o` is registered. It changes one clock after the register change that causes the change.
- R6: Bits 31:7 of both registers read as 0, and writes to those bits are ignored.
- R7: An event latches its pending bit whatever the enable bit is. Enabling a line that is already pending raises `irq_o`.
- R8: Only a 0-to-1 transition of `src_i[n]` sets pending bit n. A line held high does not set the bit again after software clears it.
- R9: If a rising edge on `src_i[n]` and a write to offset 0x00 fall in the same cycle, pending bit n ends at 1 whatever value was written.
- R10: A read of any address other than 0x00 or 0x04 returns 0. A write to such an address changes neither register.
- R11: Writing 0 to the enable register and then 0 to the pending register leaves both registers at 0 and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 7 | Event lines from the power-management logic |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level request to the parent controller |

## Verification
Pending bits are raised two ways: by a software write and by an event edge. For each, the summary output is observed with the enable bit clear and then with it set. This separates the masking function from pending storage and shows the one-cycle output latency.

A line held high after its bit is cleared separates true edge detection from level sampling. A clearing write in the same cycle as an edge checks that the hardware set takes priority. Writes of all ones, writes to unmapped addresses and the disable-then-clear sequence show that nothing outside the seven live bits is stored.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
    localparam int unsigned NUM_SRC_DEF  = 7;
    localparam int unsigned DATA_W_DEF   = 32;
    localparam int unsigned ADDR_W_DEF   = 8;
    localparam int unsigned PEND_OFF_DEF = 0;
    localparam int unsigned EN_OFF_DEF   = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/pmu_irq_edge.sv
module pmu_irq_edge #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rise
        assign rise_o[i] = src_i[i] & ~st_q.prev[i];
    end

    // A line that stays high does not produce a second edge.
    assert_held_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> ((rise_o & $past(src_i)) == '0));
endmodule

// File: rtl/pmu_irq_regs.sv
module pmu_irq_regs #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_pend_i,
    input  logic               wr_en_reg_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enab_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] enab;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_pend_i) st_d.pend = wdata_i;
        // A hardware edge always wins over the written value.
        st_d.pend = st_d.pend | rise_i;
        if (wr_en_reg_i) st_d.enab = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign enab_o = st_q.enab;

    // An edge always leaves its pending bit set, even under a clearing write.
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(rise_i)) == $past(rise_i)));

    // Without a write, the only new pending bits are the ones that saw an edge.
    assert_only_edges_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_pend_i) |=> ((pend_o & ~$past(pend_o)) == ($past(rise_i) & ~$past(pend_o))));

    // The enable register moves only on a write to it.
    assert_enab_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en_reg_i) |=> $stable(enab_o));
endmodule

// File: rtl/pmu_irq_sum.sv
module pmu_irq_sum #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] enab_i,
    output logic               irq_o
);
    typedef struct packed {
        logic irq;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(pend_i & enab_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ((pend_i & enab_i) != '0)) |=> irq_o);
    assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ((pend_i & enab_i) == '0)) |=> !irq_o);
endmodule

// File: rtl/pmu_irq_ctrl.sv
module pmu_irq_ctrl
    import pmu_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC  = NUM_SRC_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned PEND_OFF = PEND_OFF_DEF,
    parameter int unsigned EN_OFF   = EN_OFF_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFF);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFF);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] enab;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];

    always_comb begin
        if (addr_i == PEND_A)    sel = SEL_PEND;
        else if (addr_i == EN_A) sel = SEL_EN;
        else                     sel = SEL_NONE;
    end

    always_comb begin
        unique case (sel)
            SEL_PEND: rdata_o = {{PAD_W{1'b0}}, pend};
            SEL_EN:   rdata_o = {{PAD_W{1'b0}}, enab};
            default:  rdata_o = '0;
        endcase
    end

    pmu_irq_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    pmu_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .wr_pend_i   (wr_en_i && (sel == SEL_PEND)),
        .wr_en_reg_i (wr_en_i && (sel == SEL_EN)),
        .wdata_i     (wdata_i[NUM_SRC-1:0]),
        .pend_o      (pend),
        .enab_o      (enab)
    );

    pmu_irq_sum #(.NUM_SRC(NUM_SRC)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .enab_i (enab),
        .irq_o  (irq_o)
    );

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != PEND_A && addr_i != EN_A) |-> (rdata_o == '0));
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/sim_pmu_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pmu_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    pmu_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // Monitor: compares expected items against the outputs after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {31'd0, irq_o} : rdata_o;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    endtask

    task automatic wr_src(input logic [7:0] a, input logic [31:0] d, input logic [6:0] s);
        @(negedge clk); addr_i = a; wdata_i = d; wr_en_i = 1'b1; src_i = s;
    endtask

    task automatic set_src(input logic [6:0] s);
        @(negedge clk); wr_en_i = 1'b0; src_i = s;
    endtask

    task automatic idle();
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk); wr_en_i = 1'b0; addr_i = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_irq(input bit e, input string tag);
        item_t it;
        @(negedge clk); wr_en_i = 1'b0;
        it.is_irq = 1'b1; it.addr = addr_i; it.exp = {31'd0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_rd(8'h00, 32'h0, "R1 pending after reset");
        chk_rd(8'h04, 32'h0, "R1 enable after reset");
        chk_irq(1'b0, "R1 irq after reset");

        wr(8'h04, 32'hFFFF_FFFF);
        chk_rd(8'h04, 32'h0000_007F, "R6 enable upper bits / R3 write");
        wr(8'h04, 32'h0);
        wr(8'h00, 32'hFFFF_FF80);
        chk_rd(8'h00, 32'h0, "R6 pending upper bits ignored");

        wr(8'h00, 32'h05);
        chk_rd(8'h00, 32'h05, "R2 pending write replaces");
        chk_irq(1'b0, "R4 pending but disabled");
        wr(8'h04, 32'h04);
        chk_irq(1'b0, "R5 irq not yet updated");
        chk_irq(1'b1, "R5 irq one clock later / R3 enable");
        wr(8'h00, 32'h0);
        chk_rd(8'h00, 32'h0, "R2 writing 0 clears");
        chk_irq(1'b0, "R4 irq drops");

        wr(8'h04, 32'h0);
        set_src(7'h08);
        chk_rd(8'h00, 32'h08, "R7 latched while disabled");
        chk_irq(1'b0, "R7 no irq while disabled");
        wr(8'h04, 32'h08);
        idle();
        chk_irq(1'b1, "R7 enable of pending line");

        wr(8'h00, 32'h0);
        idle();
        chk_rd(8'h00, 32'h0, "R8 held line does not re-set");
        chk_irq(1'b0, "R8 irq stays low");

        wr_src(8'h00, 32'h0, 7'h28);
        chk_rd(8'h00, 32'h20, "R9 edge beats clearing write");
        wr(8'h00, 32'h0);

        wr(8'h08, 32'h7F);
        wr(8'h40, 32'h7F);
        chk_rd(8'h08, 32'h0, "R10 unmapped read");
        chk_rd(8'h00, 32'h0, "R10 pending untouched");
        chk_rd(8'h04, 32'h08, "R10 enable untouched");

        wr(8'h04, 32'h40);
        wr(8'h00, 32'h40);
        idle();
        chk_irq(1'b1, "R2 written 1 raises line");

        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);
        chk_rd(8'h04, 32'h0, "R11 enable cleared");
        chk_rd(8'h00, 32'h0, "R11 pending cleared");
        idle();
        chk_irq(1'b0, "R11 irq low");

        repeat (3) idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule